// File: doc/BRIEF.md
# Shared Bus Arbiter with Four-Word Ownership Quantum

This block decides which of four masters drives a shared system bus: a CPU (index 0), a DMA engine (index 1), an external-processor port that acts as a slave toward the outside world (index 2), and an external bus master (index 3). Each master raises a request line. The arbiter answers with a one-hot grant. A single per-beat ready input stands in for memory timing. Each clock edge on which the owner is requesting and ready is high moves one 32-bit word.

The owner keeps the bus for a quantum of four words. When the fourth word completes, the bus passes to another eligible requester, chosen in round-robin order starting after the current owner. If nobody else is waiting, the owner starts a fresh quantum. An owner that lowers its request gives the bus up at once. The next eligible master is granted on the same edge, so its grant shows one clock after the drop.

The DMA engine presents the number of the channel it is serving. When that number differs from the channel of its last transfer, the DMA request is held ineligible for 13 clocks. During that time other masters may use the bus.

Top module: `bus_quantum_arbiter`

## Requirements
- R1: While rst_ni is low, gnt_o is all zero, word_cnt_o is 0 and dma_hold_o is 0.
- R2: gnt_o is one-hot or all zero at every clock. Bit i grants master i: 0 CPU, 1 DMA, 2 external-processor port, 3 external master.
- R3: On an idle bus, an eligible requester is granted at the first clock edge that sees its request. With no request, gnt_o returns to all zero at the next edge.
- R4: word_cnt_o is 0 in the first cycle of every new grant. It advances by one at each edge where the owner's request and rdy_i are both high. It wraps from 3 to 0.
- R5: At the edge that completes the owner's fourth word, the grant moves to another eligible requester if one exists.
- R6: With no other eligible requester, the owner keeps the grant across any number of four-word quanta.
- R7: The next owner is the first eligible requester, scanning upward with wraparound from the index after the current or most recent owner. After reset the scan starts at index 0.
- R8: An owner that lowers its request loses the grant at the next edge. On that same edge the next eligible requester is granted, with word_cnt_o at 0.
- R9: While the owner is requesting, the grant does not change except at the edge that completes a fourth word.
- R10: A DMA request whose dma_ch_i differs from the channel of the last DMA word, raised while DMA is not granted, makes DMA ineligible for 13 consecutive clocks. dma_hold_o is high for those clocks except the last. DMA is granted at the 14th edge after the request first appears on an otherwise idle bus.
- R11: While the DMA penalty runs, other masters are granted as if DMA were not requesting.
- R12: A DMA request carrying the same channel as the last DMA word, or the first DMA request after reset, costs no penalty.
- R13: Clocks with rdy_i low do not count as words. With first-word latencies of 4 or 2 clocks followed by single-clock words, the handoff happens only after four ready beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Bus request per master |
| rdy_i | input | 1 | Per-beat ready from memory; a word moves when high |
| dma_ch_i | input | 2 | Channel currently served by the DMA engine |
| gnt_o | output | 4 | One-hot bus grant |
| word_cnt_o | output | 2 | Words moved by the owner in the current quantum |
| dma_hold_o | output | 1 | DMA request held back by a channel-switch penalty |

## Verification
The bench sweeps every ordered pair of owner and waiting master with back-to-back ready beats. It repeats some pairs with 4-1-1-1 and 2-1-1-1 ready patterns. A design that counted clocks instead of ready beats would hand over too early, and one that ignored the waiting master would keep the bus past the fourth word. Round-robin rotation is checked with all masters requesting and with sparse request sets that start mid-rotation. A fixed-priority design would fail these by returning to index 0. The DMA penalty is measured clock by clock, an off-by-one window would shift the grant by one clock, and the bench shows that a blocked DMA does not stall a lower-priority master or cost anything when its channel is unchanged.

// File: rtl/bqa_pkg.sv
package bqa_pkg;
  localparam int unsigned N_MST_DEF   = 4;
  localparam int unsigned QUANTUM_DEF = 4;
  localparam int unsigned DMA_GAP_DEF = 13;
  localparam int unsigned CH_W_DEF    = 2;

  typedef enum logic [1:0] {
    MST_CPU = 2'd0,
    MST_DMA = 2'd1,
    MST_XPP = 2'd2,
    MST_EXT = 2'd3
  } mst_e;

  function automatic int unsigned cnt_w(int unsigned q);
    return (q > 1) ? $clog2(q) : 1;
  endfunction
endpackage

// File: rtl/bqa_rr_pick.sv
module bqa_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand_i,
  input  logic [IW-1:0] base_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    int unsigned j;
    logic [IW-1:0] jj;
    vld_o = 1'b0;
    idx_o = '0;
    for (int unsigned k = 0; k < N; k++) begin
      j  = (int'(base_i) + k) % N;
      jj = IW'(j);
      if (!vld_o && cand_i[jj]) begin
        vld_o = 1'b1;
        idx_o = jj;
      end
    end
  end
endmodule

// File: rtl/bqa_word_cnt.sv
module bqa_word_cnt #(
  parameter int unsigned QUANTUM = 4,
  parameter int unsigned CW      = bqa_pkg::cnt_w(QUANTUM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          beat_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(QUANTUM - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (beat_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bqa_dma_gap.sv
module bqa_dma_gap #(
  parameter int unsigned DMA_GAP = 13,
  parameter int unsigned CH_W    = 2,
  parameter int unsigned GW      = $clog2(DMA_GAP + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            granted_i,
  input  logic            beat_i,
  input  logic [CH_W-1:0] ch_i,
  output logic            block_o
);
  logic [CH_W-1:0] last_ch_q;
  logic            ch_vld_q;
  logic [GW-1:0]   gap_q;
  logic            chg;

  // channel switch seen while DMA is off the bus and no penalty is running
  assign chg     = req_i && ch_vld_q && (ch_i != last_ch_q) && !granted_i && (gap_q == '0);
  assign block_o = chg || (gap_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_ch_q <= '0;
      ch_vld_q  <= 1'b0;
      gap_q     <= '0;
    end else begin
      if (chg) begin
        gap_q     <= GW'(DMA_GAP - 1);
        last_ch_q <= ch_i;
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end
      if (beat_i) begin
        last_ch_q <= ch_i;
        ch_vld_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_quantum_arbiter.sv
module bus_quantum_arbiter #(
  parameter  int unsigned N_MST   = bqa_pkg::N_MST_DEF,
  parameter  int unsigned QUANTUM = bqa_pkg::QUANTUM_DEF,
  parameter  int unsigned DMA_GAP = bqa_pkg::DMA_GAP_DEF,
  parameter  int unsigned DMA_IDX = 1,
  parameter  int unsigned CH_W    = bqa_pkg::CH_W_DEF,
  localparam int unsigned CW      = bqa_pkg::cnt_w(QUANTUM),
  localparam int unsigned IW      = $clog2(N_MST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] req_i,
  input  logic             rdy_i,
  input  logic [CH_W-1:0]  dma_ch_i,
  output logic [N_MST-1:0] gnt_o,
  output logic [CW-1:0]    word_cnt_o,
  output logic             dma_hold_o
);
  logic [IW-1:0]    owner_q;
  logic             owned_q;
  logic [N_MST-1:0] elig, others, cand, owner_mask;
  logic [IW-1:0]    base, pick_idx;
  logic             pick_vld;
  logic             own_req, beat, last, rel, arb;
  logic             dma_block, dma_owner;

  assign dma_owner = owned_q && (owner_q == IW'(DMA_IDX));

  always_comb begin
    elig          = req_i;
    elig[DMA_IDX] = req_i[DMA_IDX] && !dma_block;
  end

  assign owner_mask = owned_q ? (N_MST'(1) << owner_q) : '0;
  assign others     = elig & ~owner_mask;
  assign own_req    = owned_q && req_i[owner_q];
  assign beat       = own_req && rdy_i;
  assign rel        = owned_q && (!own_req || (beat && last && (others != '0)));
  assign arb        = !owned_q || rel;
  assign cand       = owned_q ? others : elig;
  assign base       = (owner_q == IW'(N_MST - 1)) ? '0 : owner_q + 1'b1;

  bqa_rr_pick #(.N(N_MST), .IW(IW)) i_pick (
    .cand_i (cand),
    .base_i (base),
    .vld_o  (pick_vld),
    .idx_o  (pick_idx)
  );

  bqa_word_cnt #(.QUANTUM(QUANTUM), .CW(CW)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arb),
    .beat_i (beat),
    .cnt_o  (word_cnt_o),
    .last_o (last)
  );

  bqa_dma_gap #(.DMA_GAP(DMA_GAP), .CH_W(CH_W)) i_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i[DMA_IDX]),
    .granted_i (dma_owner),
    .beat_i    (beat && dma_owner),
    .ch_i      (dma_ch_i),
    .block_o   (dma_block)
  );

  assign dma_hold_o = dma_block;

  // reset owner to the top index so the first scan starts at 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= IW'(N_MST - 1);
      owned_q <= 1'b0;
    end else if (arb) begin
      if (pick_vld) begin
        owner_q <= pick_idx;
        owned_q <= 1'b1;
      end else begin
        owned_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < N_MST; i++) begin : g_gnt
    assign gnt_o[i] = owned_q && (owner_q == IW'(i));
  end
endmodule

// File: rtl/bqa_chk.sv
module bqa_chk #(
  parameter int unsigned N_MST   = 4,
  parameter int unsigned QUANTUM = 4,
  parameter int unsigned DMA_IDX = 1,
  parameter int unsigned CW      = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] req_i,
  input logic             rdy_i,
  input logic [N_MST-1:0] gnt_o,
  input logic [CW-1:0]    word_cnt_o,
  input logic             dma_hold_o
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_cnt_o <= CW'(QUANTUM - 1));

  // R4
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(gnt_o) && gnt_o != '0) |-> word_cnt_o == '0);

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != '0 && rdy_i && word_cnt_o != CW'(QUANTUM - 1))
    |=> word_cnt_o == $past(word_cnt_o) + 1'b1);

  // R9
  gnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & req_i) != '0 && !(rdy_i && word_cnt_o == CW'(QUANTUM - 1)))
    |=> gnt_o == $past(gnt_o));

  // R3
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |=> gnt_o == '0);

  // R10
  dma_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hold_o |=> !gnt_o[DMA_IDX]);
endmodule

bind bus_quantum_arbiter bqa_chk #(
  .N_MST(N_MST), .QUANTUM(QUANTUM), .DMA_IDX(DMA_IDX), .CW(CW)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .rdy_i      (rdy_i),
  .gnt_o      (gnt_o),
  .word_cnt_o (word_cnt_o),
  .dma_hold_o (dma_hold_o)
);

// File: tb/test_bus_quantum_arbiter.sv
module test_bus_quantum_arbiter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic       rdy_i = 1'b0;
  logic [1:0] dma_ch_i = '0;
  logic [3:0] gnt_o;
  logic [1:0] word_cnt_o;
  logic       dma_hold_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_quantum_arbiter i_bus_quantum_arbiter (
    .clk_i, .rst_ni, .req_i, .rdy_i, .dma_ch_i, .gnt_o, .word_cnt_o, .dma_hold_o
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni   = 1'b0;
    req_i    = '0;
    rdy_i    = 1'b0;
    dma_ch_i = '0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(gnt_o == '0, "R1 gnt", int'(gnt_o), 0);
    chk(word_cnt_o == '0, "R1 cnt", int'(word_cnt_o), 0);
    chk(dma_hold_o == 1'b0, "R1 hold", int'(dma_hold_o), 0);
    rst_ni = 1'b1;
  endtask

  function automatic int next_rr(input int cur, input logic [3:0] mask);
    for (int k = 1; k <= 4; k++)
      if (mask[(cur + k) % 4]) return (cur + k) % 4;
    return cur;
  endfunction

  // owner a granted alone, then b waits; first word takes lat clocks
  task automatic handoff(input int a, input int b, input int lat);
    int beats, wl;
    bit r;
    do_reset();
    req_i = 4'(1 << a);
    @(negedge clk_i);
    chk(gnt_o == 4'(1 << a), "R3 first grant", int'(gnt_o), 1 << a);
    req_i = 4'((1 << a) | (1 << b));
    beats = 0;
    wl = lat - 1;
    for (int k = 0; k < 40 && beats < 4; k++) begin
      r = (wl == 0);
      if (!r) wl--;
      rdy_i = r;
      @(negedge clk_i);
      if (r) beats++;
      if (beats < 4) begin
        chk(gnt_o == 4'(1 << a), lat > 1 ? "R13 hold owner" : "R5 hold owner",
            int'(gnt_o), 1 << a);
        chk(int'(word_cnt_o) == beats, "R4 count", int'(word_cnt_o), beats);
      end else begin
        chk(gnt_o == 4'(1 << b), lat > 1 ? "R13 handoff" : "R5 handoff",
            int'(gnt_o), 1 << b);
        chk(word_cnt_o == '0, "R4 clear on grant", int'(word_cnt_o), 0);
      end
    end
    rdy_i = 1'b0;
  endtask

  // rotation under a fixed request mask, starting with owner first
  task automatic rotate(input int first, input logic [3:0] mask, input int quanta);
    int cur;
    do_reset();
    req_i = 4'(1 << first);
    @(negedge clk_i);
    req_i = mask;
    rdy_i = 1'b1;
    cur = first;
    for (int k = 0; k < quanta * 4; k++) begin
      if (k > 0 && k % 4 == 0) cur = next_rr(cur, mask);
      chk(gnt_o == 4'(1 << cur), "R7 rotation", int'(gnt_o), 1 << cur);
      @(negedge clk_i);
    end
    rdy_i = 1'b0;
  endtask

  initial begin
    // R5 R13 R4: every owner/waiter pair, plus slow first words
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        if (a != b) handoff(a, b, 1);
    handoff(0, 1, 4);
    handoff(2, 3, 4);
    handoff(3, 0, 2);
    handoff(1, 2, 2);

    // R6: single owner keeps the bus, count wraps
    do_reset();
    req_i = 4'b0001;
    rdy_i = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk_i);
      chk(gnt_o == 4'b0001, "R6 keep", int'(gnt_o), 1);
      chk(int'(word_cnt_o) == (k - 1) % 4, "R4 wrap", int'(word_cnt_o), (k - 1) % 4);
    end

    // R7: full and sparse rotations
    rotate(0, 4'b1111, 8);
    rotate(1, 4'b1010, 4);
    rotate(2, 4'b1101, 6);

    // R8: early drop hands over at once; R3 idle afterwards
    do_reset();
    req_i = 4'b0001;
    @(negedge clk_i);
    req_i = 4'b0101;
    rdy_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(word_cnt_o == 2'd2, "R4 mid count", int'(word_cnt_o), 2);
    req_i = 4'b0100;
    @(negedge clk_i);
    chk(gnt_o == 4'b0100, "R8 drop handoff", int'(gnt_o), 4);
    chk(word_cnt_o == '0, "R8 count clear", int'(word_cnt_o), 0);
    req_i = '0;
    @(negedge clk_i);
    chk(gnt_o == '0, "R3 release idle", int'(gnt_o), 0);

    // R12: first DMA request and same-channel request have no penalty
    do_reset();
    req_i = 4'b0010;
    dma_ch_i = 2'd0;
    rdy_i = 1'b1;
    @(negedge clk_i);
    chk(gnt_o == 4'b0010, "R12 first dma", int'(gnt_o), 2);
    @(negedge clk_i);
    req_i = '0;
    @(negedge clk_i);
    req_i = 4'b0010;
    #1;
    chk(dma_hold_o == 1'b0, "R12 no hold", int'(dma_hold_o), 0);
    @(negedge clk_i);
    chk(gnt_o == 4'b0010, "R12 same channel", int'(gnt_o), 2);
    @(negedge clk_i);
    req_i = '0;
    rdy_i = 1'b0;
    @(negedge clk_i);

    // R10: channel change, 13-clock penalty on an idle bus
    req_i = 4'b0010;
    dma_ch_i = 2'd1;
    #1;
    chk(dma_hold_o == 1'b1, "R10 hold start", int'(dma_hold_o), 1);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk_i);
      chk(gnt_o == '0, "R10 blocked", int'(gnt_o), 0);
      chk(dma_hold_o == (i <= 12), "R10 hold window", int'(dma_hold_o), int'(i <= 12));
    end
    @(negedge clk_i);
    chk(gnt_o == 4'b0010, "R10 grant after gap", int'(gnt_o), 2);
    rdy_i = 1'b1;
    @(negedge clk_i);
    req_i = 4'b1000;
    @(negedge clk_i);
    chk(gnt_o == 4'b1000, "R8 drop to ext", int'(gnt_o), 8);
    @(negedge clk_i);
    req_i = '0;
    rdy_i = 1'b0;
    @(negedge clk_i);

    // R11: blocked DMA does not stop master 2 (scan starts at 0)
    req_i = 4'b0110;
    dma_ch_i = 2'd2;
    @(negedge clk_i);
    chk(gnt_o == 4'b0100, "R11 other master in gap", int'(gnt_o), 4);
    chk(dma_hold_o == 1'b1, "R11 hold", int'(dma_hold_o), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule